// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is the arithmetic core of a processor execution stage. It multiplies two 32-bit operands and then adds the product to an addend or subtracts it from the addend. The addend is 32 or 64 bits wide. The operation can be signed or unsigned. The exact result is clamped to the range of the chosen result width and lands in an output register one cycle after the request.

Each operation also reports four status flags:
- **Overflow** says whether the result had to be clamped.
- **Advance-overflow** is the XOR of the two most significant bits of the clamped result. It warns that the value is close to the edge of its range.
- **Sticky overflow** and **sticky advance-overflow** are held in an internal status register. They gather the two flags above across operations until a clear input resets them.

The unit accepts one operation per cycle and needs no handshake.

Top module: `sat_mac_unit`

## Requirements
- R1: An operation presented with `in_valid` high produces `res_valid` high on the following cycle, together with its result, `flag_v` and `flag_av`. When `in_valid` is low, `res_valid` is low on the following cycle and `result`, `flag_v` and `flag_av` keep their values.
- R2: Opcode bit 2 selects subtract (1) or add (0), bit 1 selects unsigned (1) or signed (0), and bit 0 selects 64-bit (1) or 32-bit (0) result width. The unclamped value is addend plus or minus the exact product `op_a * op_b`, and nothing wraps in between.
- R3: In signed 32-bit forms the operands and the addend's low 32 bits are sign-extended, and the result is clamped to [-2^31, 2^31-1]. Addend bits 63:32 are ignored. The 32-bit result sits in `result[31:0]` with `result[63:32]` zero.
- R4: In unsigned 32-bit forms the values are zero-extended and the result is clamped to [0, 2^32-1]. Addend bits 63:32 are ignored, and `result[63:32]` is zero.
- R5: In signed 64-bit forms the full 64-bit addend is used. A result above 2^63-1 becomes 64'h7FFF_FFFF_FFFF_FFFF, and a result below -2^63 becomes 64'h8000_0000_0000_0000.
- R6: In unsigned 64-bit forms a sum that carries past bit 63 becomes all ones, and a difference below zero becomes zero.
- R7: `flag_v` is 1 for an operation whose result was clamped and 0 for one that was not.
- R8: `flag_sv` is set by any clamped operation and stays set until a cycle with `clr_sticky` high. A clamped operation in the same cycle as the clear leaves it set.
- R9: `flag_av` is the XOR of the two most significant bits of the clamped result: bits 63 and 62 in 64-bit forms, bits 31 and 30 in 32-bit forms.
- R10: `flag_sav` is set whenever an operation's `flag_av` is 1 and is cleared by `clr_sticky`, with the same same-cycle priority as R8.
- R11: After reset, `res_valid`, `result` and all four flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation request for this cycle |
| opcode | input | 3 | {subtract, unsigned, wide} |
| op_a | input | 32 | First multiplier operand |
| op_b | input | 32 | Second multiplier operand |
| addend | input | 64 | Accumulator value (low 32 bits in 32-bit forms) |
| clr_sticky | input | 1 | Synchronous clear of the sticky flags |
| res_valid | output | 1 | Result register holds a new operation |
| result | output | 64 | Clamped result |
| flag_v | output | 1 | Last operation was clamped |
| flag_sv | output | 1 | Sticky overflow |
| flag_av | output | 1 | Advance-overflow of last result |
| flag_sav | output | 1 | Sticky advance-overflow |

## Verification
The hardest case to reach is the unsigned 64-bit add whose true sum needs a 65th bit. It occurs only when a near-maximal product meets a near-maximal addend, so random operands almost never produce it. The stimulus sweeps every opcode across the extreme operand values (zero, all ones, most positive, most negative) for both the multipliers and the addend, which lands on that carry and on the signed clamp edges. The same sweep covers the advance-overflow case without overflow, where a product of 2^62 sets only the top-bit warning.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  // Opcode layout: bit 2 subtract, bit 1 unsigned, bit 0 wide result
  typedef struct packed {
    logic sub;
    logic uns;
    logic wide;
  } mac_op_t;
endpackage

// File: rtl/sat_mac_operand.sv
module sat_mac_operand
  import sat_mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  mac_op_t               op,
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  input  logic [2*W-1:0]        addend,
  output logic [2*W+1:0]        prod_x,
  output logic [2*W+1:0]        add_x
);
  localparam int unsigned DW = 2 * W;
  localparam int unsigned EW = DW + 2;

  function automatic logic [EW-1:0] widen_n(input logic [W-1:0] v, input logic uns);
    return uns ? {{(EW-W){1'b0}}, v} : {{(EW-W){v[W-1]}}, v};
  endfunction

  function automatic logic [EW-1:0] widen_d(input logic [DW-1:0] v, input logic uns);
    return uns ? {{(EW-DW){1'b0}}, v} : {{(EW-DW){v[DW-1]}}, v};
  endfunction

  logic [EW-1:0] ea, eb;

  always_comb begin
    ea     = widen_n(a, op.uns);
    eb     = widen_n(b, op.uns);
    // exact product fits in EW bits, so the truncated multiply is exact
    prod_x = ea * eb;
    add_x  = op.wide ? widen_d(addend, op.uns) : widen_n(addend[W-1:0], op.uns);
  end
endmodule

// File: rtl/sat_mac_accum.sv
module sat_mac_accum
  import sat_mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  mac_op_t         op,
  input  logic [2*W+1:0]  prod_x,
  input  logic [2*W+1:0]  add_x,
  output logic [2*W-1:0]  res,
  output logic            sat_hi,
  output logic            sat_lo,
  output logic            av
);
  localparam int unsigned DW = 2 * W;
  localparam int unsigned EW = DW + 2;
  localparam logic [EW-1:0] ONE = {{(EW-1){1'b0}}, 1'b1};

  function automatic logic [EW-1:0] ceiling(input mac_op_t o);
    logic [EW-1:0] span;
    span = o.wide ? (ONE << DW) : (ONE << W);
    return o.uns ? span - ONE : (span >> 1) - ONE;
  endfunction

  function automatic logic [EW-1:0] floor_val(input mac_op_t o);
    logic [EW-1:0] half;
    half = o.wide ? (ONE << (DW-1)) : (ONE << (W-1));
    return o.uns ? '0 : ~(half - ONE);
  endfunction

  function automatic logic [EW-1:0] combine(input mac_op_t o, input logic [EW-1:0] acc,
                                            input logic [EW-1:0] p);
    return o.sub ? acc - p : acc + p;
  endfunction

  logic [EW-1:0] sum, hi, lo, clamped;

  always_comb begin
    sum     = combine(op, add_x, prod_x);
    hi      = ceiling(op);
    lo      = floor_val(op);
    sat_hi  = $signed(sum) > $signed(hi);
    sat_lo  = $signed(sum) < $signed(lo);
    clamped = sat_hi ? hi : (sat_lo ? lo : sum);
    res     = op.wide ? clamped[DW-1:0] : {{W{1'b0}}, clamped[W-1:0]};
    av      = op.wide ? (clamped[DW-1] ^ clamped[DW-2]) : (clamped[W-1] ^ clamped[W-2]);
  end
endmodule

// File: rtl/sat_mac_status.sv
module sat_mac_status (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  logic ovf,
  input  logic av,
  output logic sv,
  output logic sav
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv  <= 1'b0;
      sav <= 1'b0;
    end else begin
      sv  <= (sv  & ~clr) | (upd & ovf);
      sav <= (sav & ~clr) | (upd & av);
    end
  end
endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
  import sat_mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      opcode,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic [2*W-1:0]  addend,
  input  logic            clr_sticky,
  output logic            res_valid,
  output logic [2*W-1:0]  result,
  output logic            flag_v,
  output logic            flag_sv,
  output logic            flag_av,
  output logic            flag_sav
);
  localparam int unsigned DW = 2 * W;
  localparam int unsigned EW = DW + 2;

  mac_op_t        op;
  logic [EW-1:0]  prod_x, add_x;
  logic [DW-1:0]  res_now;
  logic           sat_hi_now, sat_lo_now, ovf_now, av_now;

  assign op      = mac_op_t'(opcode);
  assign ovf_now = sat_hi_now | sat_lo_now;

  sat_mac_operand #(.W(W)) u_operand (
    .op(op), .a(op_a), .b(op_b), .addend(addend),
    .prod_x(prod_x), .add_x(add_x)
  );

  sat_mac_accum #(.W(W)) u_accum (
    .op(op), .prod_x(prod_x), .add_x(add_x),
    .res(res_now), .sat_hi(sat_hi_now), .sat_lo(sat_lo_now), .av(av_now)
  );

  sat_mac_status u_status (
    .clk(clk), .rst_n(rst_n), .clr(clr_sticky), .upd(in_valid),
    .ovf(ovf_now), .av(av_now), .sv(flag_sv), .sav(flag_sav)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      result    <= '0;
      flag_v    <= 1'b0;
      flag_av   <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        result  <= res_now;
        flag_v  <= ovf_now;
        flag_av <= av_now;
      end
    end
  end
endmodule

// File: rtl/sat_mac_unit_chk.sv
module sat_mac_unit_chk #(
  parameter int unsigned W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [2:0]      opcode,
  input logic            clr_sticky,
  input logic            res_valid,
  input logic [2*W-1:0]  result,
  input logic            flag_v,
  input logic            flag_sv,
  input logic            flag_av,
  input logic            flag_sav,
  input logic            ovf_now,
  input logic            av_now,
  input logic            sat_hi_now,
  input logic            sat_lo_now
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && $stable(result) && $stable(flag_v))); // R1
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !opcode[0]) |=> (result[2*W-1:W] == '0)); // R3
  AST_UNS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[1] && sat_lo_now) |=> (result == '0)); // R6
  AST_UNS_WIDE_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'b011 && sat_hi_now) |=> (result == '1)); // R6
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (flag_v == $past(ovf_now))); // R7
  AST_SV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovf_now) |=> flag_sv); // R8
  AST_SV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_sv && !clr_sticky) |=> flag_sv); // R8
  AST_SV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sticky && !(in_valid && ovf_now)) |=> !flag_sv); // R8
  AST_SAV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && av_now) |=> (flag_sav && flag_av)); // R10
  AST_SAV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_sav && !clr_sticky) |=> flag_sav); // R10
endmodule

bind sat_mac_unit sat_mac_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .clr_sticky(clr_sticky), .res_valid(res_valid), .result(result),
  .flag_v(flag_v), .flag_sv(flag_sv), .flag_av(flag_av), .flag_sav(flag_sav),
  .ovf_now(ovf_now), .av_now(av_now), .sat_hi_now(sat_hi_now), .sat_lo_now(sat_lo_now)
);

// File: tb/sat_mac_unit_test.sv
module sat_mac_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  opcode = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [63:0] addend = '0;
  logic        clr_sticky = 1'b0;
  logic        res_valid, flag_v, flag_sv, flag_av, flag_sav;
  logic [63:0] result;

  int n_run = 0, n_fail = 0;
  logic sv_m = 1'b0, sav_m = 1'b0;

  always #2 clk = ~clk;

  sat_mac_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .addend(addend), .clr_sticky(clr_sticky),
    .res_valid(res_valid), .result(result), .flag_v(flag_v), .flag_sv(flag_sv),
    .flag_av(flag_av), .flag_sav(flag_sav)
  );

  // {opcode, a, b, addend, expected result, expected V, expected AV}
  localparam int NV = 12;
  localparam logic [196:0] VEC [NV] = '{
    {3'b000, 32'd3, 32'd4, 64'd5, 64'd17, 1'b0, 1'b0},
    {3'b010, 32'hFFFF_FFFF, 32'd2, 64'd0, 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0},
    {3'b000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 64'd0, 64'h0000_0000_7FFF_FFFF, 1'b1, 1'b1},
    {3'b100, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 64'd0, 64'h0000_0000_8000_0000, 1'b1, 1'b1},
    {3'b110, 32'd1, 32'd2, 64'd1, 64'd0, 1'b1, 1'b0},
    {3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0},
    {3'b111, 32'd2, 32'd3, 64'd5, 64'd0, 1'b1, 1'b0},
    {3'b001, 32'd1, 32'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b1},
    {3'b101, 32'd1, 32'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 1'b1},
    {3'b001, 32'h8000_0000, 32'h8000_0000, 64'd0, 64'h4000_0000_0000_0000, 1'b0, 1'b1},
    {3'b010, 32'd0, 32'd0, 64'hFFFF_FFFF_0000_0001, 64'd1, 1'b0, 1'b0},
    {3'b000, 32'hFFFF_FFFF, 32'd1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFE, 1'b0, 1'b0}
  };

  localparam logic [31:0] C32 [4] = '{32'd0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
  localparam logic [63:0] C64 [4] = '{64'd0, 64'hFFFF_FFFF_FFFF_FFFF,
                                      64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000};

  // Reference: exact 128-bit arithmetic, range test by shifting out the kept bits
  function automatic logic [65:0] ref_mac(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [63:0] ad);
    logic signed [127:0] ea, eb, ead, s, rest;
    logic [63:0] r, mask, smax, smin;
    logic v;
    int n;
    n    = op[0] ? 64 : 32;
    mask = op[0] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    smax = mask >> 1;
    smin = op[0] ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
    ea   = op[1] ? $signed({96'd0, a}) : $signed({{96{a[31]}}, a});
    eb   = op[1] ? $signed({96'd0, b}) : $signed({{96{b[31]}}, b});
    if (op[0]) ead = op[1] ? $signed({64'd0, ad}) : $signed({{64{ad[63]}}, ad});
    else       ead = op[1] ? $signed({96'd0, ad[31:0]}) : $signed({{96{ad[31]}}, ad[31:0]});
    s = op[2] ? ead - ea * eb : ead + ea * eb;
    if (op[1]) begin
      rest = s >>> n;
      v = (rest != 0);
      r = v ? ((s < 0) ? 64'd0 : mask) : (s[63:0] & mask);
    end else begin
      rest = s >>> (n - 1);
      v = !(rest == 0 || rest == -128'sd1);
      r = v ? ((s < 0) ? smin : smax) : (s[63:0] & mask);
    end
    return {r, v, op[0] ? (r[63] ^ r[62]) : (r[31] ^ r[30])};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [63:0] ad, input logic clr);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; op_a = a; op_b = b; addend = ad; clr_sticky = clr;
    @(negedge clk);
    in_valid = 1'b0; clr_sticky = 1'b0;
  endtask

  // compare the registered outputs with an expected triple and the sticky model
  task automatic expect_out(input logic [63:0] er, input logic ev, input logic eav,
                            input logic clr, input string tag);
    sv_m  = (sv_m  & ~clr) | ev;
    sav_m = (sav_m & ~clr) | eav;
    check(res_valid == 1'b1, {tag, " R1 res_valid"}, {63'd0, res_valid}, 64'd1);
    check(result == er,      {tag, " R2 result"}, result, er);
    check(flag_v == ev,      {tag, " R7 flag_v"}, {63'd0, flag_v}, {63'd0, ev});
    check(flag_av == eav,    {tag, " R9 flag_av"}, {63'd0, flag_av}, {63'd0, eav});
    check(flag_sv == sv_m,   {tag, " R8 flag_sv"}, {63'd0, flag_sv}, {63'd0, sv_m});
    check(flag_sav == sav_m, {tag, " R10 flag_sav"}, {63'd0, flag_sav}, {63'd0, sav_m});
  endtask

  task automatic ref_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [63:0] ad, input string tag);
    logic [65:0] e;
    e = ref_mac(op, a, b, ad);
    run_op(op, a, b, ad, 1'b0);
    expect_out(e[65:2], e[1], e[0], 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check({res_valid, flag_v, flag_sv, flag_av, flag_sav} == 5'b0, "R11 flags at reset",
          {59'd0, res_valid, flag_v, flag_sv, flag_av, flag_sav}, 64'd0);
    check(result == 64'd0, "R11 result at reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // hand-computed vector table (R3, R4, R5, R6, R9 corners)
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][196:194], VEC[i][193:162], VEC[i][161:130], VEC[i][129:66], 1'b0);
      expect_out(VEC[i][65:2], VEC[i][1], VEC[i][0], 1'b0, $sformatf("vec%0d R3 R4 R5 R6", i));
    end

    // R1: idle cycle keeps result, drops res_valid
    begin
      logic [63:0] held;
      held = result;
      @(negedge clk);
      check(res_valid == 1'b0, "R1 idle res_valid", {63'd0, res_valid}, 64'd0);
      check(result == held, "R1 idle result held", result, held);
    end

    // corner sweep over every opcode
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int k = 0; k < 4; k++)
            ref_op(o[2:0], C32[i], C32[j], C64[k], $sformatf("corner op%0d R2", o));

    // random operands per opcode
    for (int o = 0; o < 8; o++)
      for (int n = 0; n < 100; n++)
        ref_op(o[2:0], $urandom, $urandom, {$urandom, $urandom}, $sformatf("rand op%0d R2", o));

    // R8/R10: sticky flags survive a clean operation
    run_op(3'b000, 32'd1, 32'd1, 64'd1, 1'b0);
    expect_out(64'd2, 1'b0, 1'b0, 1'b0, "R8 R10 sticky after clean op");
    // clear pulse with no operation
    @(negedge clk);
    clr_sticky = 1'b1;
    @(negedge clk);
    clr_sticky = 1'b0;
    sv_m = 1'b0; sav_m = 1'b0;
    check(flag_sv == 1'b0, "R8 clear sv", {63'd0, flag_sv}, 64'd0);
    check(flag_sav == 1'b0, "R10 clear sav", {63'd0, flag_sav}, 64'd0);
    // overflow in the same cycle as the clear keeps sticky set
    run_op(3'b001, 32'd1, 32'd1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1);
    expect_out(64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1, "R8 R10 clear vs overflow");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule